// File: doc/BRIEF.md
# Data Object Mailbox Register Block

This block is a small register window through which software passes request data objects to an on-chip responder and collects the replies. Software writes the request one dword at a time into a request buffer, then sets the start bit in the control register. The block checks the first request dword against a table of supported protocols. It also checks that the number of dwords written equals the length carried in the second dword. If both checks pass, the block marks itself busy and hands the request to a responder over a start/done/discard handshake.

The responder reads the request buffer by index and appends its reply dwords to a response buffer. When it reports completion, the block raises a ready flag. Software then reads the current reply dword from the read-mailbox register and moves to the next one by writing any value to that register. When the last reply dword has been consumed, both buffers empty and ready drops. An abort bit in the control register clears the exchange at any time. A one-cycle interrupt request fires when ready or error becomes set, but only if interrupts are supported and enabled.

Top module: `mbox_regif`

## Requirements
- R1: After reset, the status register, the control register and `irq` all read 0.
- R2: The capabilities register at byte offset 0x04 reads the interrupt-supported parameter in bit 0 and the interrupt message number in bits 11:1. Offset 0x00 and every offset from 0x18 upward read 0.
- R3: The control register is at 0x08. Bit 1 (interrupt enable) is stored from every control write. Reads always return bit 0 (abort) and bit 31 (start) as 0.
- R4: Each write to 0x10 appends one dword to the request buffer, which holds DEPTH dwords. A write to a full buffer is dropped and marks the buffer overflowed. An overflowed request is discarded at start even when its length field matches, and the next request is accepted normally.
- R5: A start (control bit 31 set, bit 0 clear, block not busy) accepts the request only if all of the following hold: request dword 0 equals {8'h00, type[7:0], vendor[15:0]} of some table entry; at least two dwords were written; and bits 17:0 of dword 1 equal the dword count. On acceptance `rsp_start` pulses for one cycle with the entry index on `rsp_proto`, and status bit 0 (busy) sets.
- R6: A start that fails the protocol or length check is discarded silently. No `rsp_start` pulse occurs, error and ready stay clear, and both buffers empty so that the next request starts from dword 0.
- R7: `rsp_done` while busy sets status bit 31 (ready) and clears busy. A read of 0x14 returns the current reply dword while ready is set and 0 otherwise.
- R8: A write of any value to 0x14 while ready moves to the next reply dword. The write that consumes the last dword clears ready and empties both buffers.
- R9: A control write with bit 0 set clears ready, error and busy and empties both buffers. It takes priority over a start bit in the same write.
- R10: `rsp_discard` while busy clears busy, sets status bit 2 (error) and empties both buffers.
- R11: `irq` pulses for one cycle when ready or error goes from 0 to 1, only if the interrupt-supported parameter and the enable bit are both 1. Status bit 1 sets together with the pulse and is cleared by writing 1 to status bit 1 (offset 0x0C).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 5 | Byte offset within the window (bits 1:0 ignored) |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, valid in the cycle of `reg_rd`, 0 otherwise |
| rsp_start | output | 1 | One-cycle pulse handing an accepted request to the responder |
| rsp_proto | output | PW | Table index of the accepted protocol |
| rq_idx | input | IW | Request-buffer index read by the responder |
| rq_data | output | 32 | Request dword at `rq_idx` |
| rs_we | input | 1 | Responder appends `rs_data` to the reply (only while busy) |
| rs_data | input | 32 | Reply dword |
| rsp_done | input | 1 | Responder finished, reply complete |
| rsp_discard | input | 1 | Responder rejects the request |
| irq | output | 1 | One-cycle interrupt request |

## Verification
The hardest cases to reach are the discard paths, because each one leaves the status register looking just like an idle block.

To expose the silent discards, the bench follows each rejected start with a valid request. It then checks that the first reply dword is the one the responder built from a request that starts at dword 0. Leftover dwords from the rejected request would shift the header and break the protocol match.

The overflow case is reached by writing one dword more than DEPTH while declaring a length of exactly DEPTH. The count therefore matches and only the overflow flag can cause the discard.

A responder model in the bench holds busy for several cycles before replying, so that the status register can be sampled mid-exchange.

// File: rtl/mbox_pkg.sv
package mbox_pkg;

  localparam int DW     = 32;
  localparam int AW     = 5;
  localparam int LEN_W  = 18;

  // register select decoded from dword offset reg_addr[4:2]
  typedef enum logic [2:0] {
    SEL_HDR  = 3'd0,
    SEL_CAP  = 3'd1,
    SEL_CTL  = 3'd2,
    SEL_STS  = 3'd3,
    SEL_WMB  = 3'd4,
    SEL_RMB  = 3'd5,
    SEL_NONE = 3'd7
  } reg_sel_e;

  // control and status bit positions
  localparam int CTL_ABORT = 0;
  localparam int CTL_IEN   = 1;
  localparam int CTL_START = 31;
  localparam int STS_BUSY  = 0;
  localparam int STS_ISTS  = 1;
  localparam int STS_ERR   = 2;
  localparam int STS_RDY   = 31;

  function automatic reg_sel_e decode_sel(input logic [AW-1:0] addr);
    case (addr[AW-1:2])
      3'd0:    decode_sel = SEL_HDR;
      3'd1:    decode_sel = SEL_CAP;
      3'd2:    decode_sel = SEL_CTL;
      3'd3:    decode_sel = SEL_STS;
      3'd4:    decode_sel = SEL_WMB;
      3'd5:    decode_sel = SEL_RMB;
      default: decode_sel = SEL_NONE;
    endcase
  endfunction

endpackage

// File: rtl/mbox_reqbuf.sv
module mbox_reqbuf #(
  parameter int DEPTH = 16,
  localparam int CW = $clog2(DEPTH + 1),
  localparam int IW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic [31:0]   push_data,
  input  logic          flush,
  input  logic [IW-1:0] rd_idx,
  output logic [31:0]   rd_data,
  output logic [31:0]   hdr0,
  output logic [31:0]   hdr1,
  output logic [CW-1:0] count,
  output logic          ovf
);

  logic [31:0]   mem [DEPTH];
  logic [CW-1:0] count_q, count_d;
  logic          ovf_q, ovf_d;
  logic          full;
  logic          wr_en;

  assign full  = (count_q == CW'(DEPTH));
  assign wr_en = push & ~full & ~flush;

  always_comb begin
    count_d = count_q;
    ovf_d   = ovf_q;
    if (flush) begin
      count_d = '0;
      ovf_d   = 1'b0;
    end else if (push) begin
      if (full) ovf_d   = 1'b1;
      else      count_d = count_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count_q <= '0;
      ovf_q   <= 1'b0;
    end else begin
      count_q <= count_d;
      ovf_q   <= ovf_d;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en) mem[count_q[IW-1:0]] <= push_data;
  end

  assign rd_data = mem[rd_idx];
  assign hdr0    = mem[0];
  assign hdr1    = mem[1];
  assign count   = count_q;
  assign ovf     = ovf_q;

  // R4: occupancy never exceeds the buffer depth
  a_r4_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
    count_q <= CW'(DEPTH));

  // R4: a push into a full buffer leaves the occupancy unchanged
  a_r4_full_drop: assert property (@(posedge clk) disable iff (!rst_n)
    (push && full && !flush) |=> (count_q == CW'(DEPTH)) && ovf_q);

endmodule

// File: rtl/mbox_rspbuf.sv
module mbox_rspbuf #(
  parameter int DEPTH = 16,
  localparam int CW = $clog2(DEPTH + 1),
  localparam int IW = $clog2(DEPTH)
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        push,
  input  logic [31:0] push_data,
  input  logic        advance,
  input  logic        flush,
  output logic [31:0] cur_data,
  output logic        last
);

  logic [31:0]   mem [DEPTH];
  logic [CW-1:0] len_q, len_d;
  logic [CW-1:0] idx_q, idx_d;
  logic          full;
  logic          wr_en;

  assign full  = (len_q == CW'(DEPTH));
  assign wr_en = push & ~full & ~flush;
  assign last  = ((idx_q + 1'b1) >= len_q);

  always_comb begin
    len_d = len_q;
    idx_d = idx_q;
    if (flush) begin
      len_d = '0;
      idx_d = '0;
    end else begin
      if (wr_en)   len_d = len_q + 1'b1;
      if (advance) idx_d = idx_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      len_q <= '0;
      idx_q <= '0;
    end else begin
      len_q <= len_d;
      idx_q <= idx_d;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en) mem[len_q[IW-1:0]] <= push_data;
  end

  assign cur_data = (idx_q < CW'(DEPTH)) ? mem[idx_q[IW-1:0]] : '0;

  // R8: a flush leaves the response buffer empty and rewound
  a_r8_flush_empty: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (len_q == '0) && (idx_q == '0));

endmodule

// File: rtl/mbox_match.sv
module mbox_match #(
  parameter int NUM_PROTO = 2,
  parameter logic [NUM_PROTO*24-1:0] PROTO_TABLE = {24'h01_0001, 24'h00_0001},
  localparam int PW = (NUM_PROTO > 1) ? $clog2(NUM_PROTO) : 1
) (
  input  logic [31:0]   dword0,
  output logic          hit,
  output logic [PW-1:0] hit_idx
);

  logic [NUM_PROTO-1:0] eq;

  for (genvar g = 0; g < NUM_PROTO; g++) begin : g_cmp
    assign eq[g] = (dword0 == {8'h00, PROTO_TABLE[g*24 +: 24]});
  end

  // lowest matching index wins
  always_comb begin
    hit     = 1'b0;
    hit_idx = '0;
    for (int i = NUM_PROTO - 1; i >= 0; i--) begin
      if (eq[i]) begin
        hit     = 1'b1;
        hit_idx = PW'(i);
      end
    end
  end

endmodule

// File: rtl/mbox_regif.sv
module mbox_regif
  import mbox_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int NUM_PROTO = 2,
  parameter logic [NUM_PROTO*24-1:0] PROTO_TABLE = {24'h01_0001, 24'h00_0001},
  parameter bit INTR_SUP = 1'b1,
  parameter logic [10:0] INTR_MSG = 11'h005,
  localparam int CW = $clog2(DEPTH + 1),
  localparam int IW = $clog2(DEPTH),
  localparam int PW = (NUM_PROTO > 1) ? $clog2(NUM_PROTO) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_wr,
  input  logic          reg_rd,
  input  logic [4:0]    reg_addr,
  input  logic [31:0]   reg_wdata,
  output logic [31:0]   reg_rdata,
  output logic          rsp_start,
  output logic [PW-1:0] rsp_proto,
  input  logic [IW-1:0] rq_idx,
  output logic [31:0]   rq_data,
  input  logic          rs_we,
  input  logic [31:0]   rs_data,
  input  logic          rsp_done,
  input  logic          rsp_discard,
  output logic          irq
);

  reg_sel_e sel;
  assign sel = decode_sel(reg_addr);

  // state
  logic busy_q, busy_d;
  logic ready_q, ready_d;
  logic error_q, error_d;
  logic ien_q, ien_d;
  logic ists_q, ists_d;
  logic irq_q, irq_d;
  logic start_q, start_d;
  logic [PW-1:0] proto_q, proto_d;

  // buffer interfaces
  logic [31:0]   hdr0, hdr1, rsp_cur;
  logic [CW-1:0] req_cnt;
  logic          req_ovf, rsp_last;
  logic          hit;
  logic [PW-1:0] hit_idx;

  // decoded events
  logic wr_ctl, wr_sts, wr_wmb, wr_rmb;
  logic abort, go, len_ok, go_ok, done_ok, disc_ok;
  logic advance, drain_last, flush_all, req_flush, rsp_push;

  assign wr_ctl = reg_wr && (sel == SEL_CTL);
  assign wr_sts = reg_wr && (sel == SEL_STS);
  assign wr_wmb = reg_wr && (sel == SEL_WMB);
  assign wr_rmb = reg_wr && (sel == SEL_RMB);

  assign abort   = wr_ctl & reg_wdata[CTL_ABORT];
  assign go      = wr_ctl & reg_wdata[CTL_START] & ~reg_wdata[CTL_ABORT] & ~busy_q;
  assign len_ok  = (req_cnt >= CW'(2)) && (hdr1[LEN_W-1:0] == LEN_W'(req_cnt));
  assign go_ok   = go & hit & ~req_ovf & len_ok;
  assign done_ok = rsp_done & busy_q & ~abort;
  assign disc_ok = rsp_discard & ~rsp_done & busy_q & ~abort;

  assign advance    = wr_rmb & ready_q & ~abort;
  assign drain_last = advance & rsp_last;
  assign flush_all  = abort | (go & ~go_ok) | disc_ok | drain_last;
  assign req_flush  = flush_all | done_ok;
  assign rsp_push   = rs_we & busy_q & ~abort;

  mbox_reqbuf #(.DEPTH(DEPTH)) u_req (
    .clk       (clk),
    .rst_n     (rst_n),
    .push      (wr_wmb),
    .push_data (reg_wdata),
    .flush     (req_flush),
    .rd_idx    (rq_idx),
    .rd_data   (rq_data),
    .hdr0      (hdr0),
    .hdr1      (hdr1),
    .count     (req_cnt),
    .ovf       (req_ovf)
  );

  mbox_rspbuf #(.DEPTH(DEPTH)) u_rsp (
    .clk       (clk),
    .rst_n     (rst_n),
    .push      (rsp_push),
    .push_data (rs_data),
    .advance   (advance),
    .flush     (flush_all),
    .cur_data  (rsp_cur),
    .last      (rsp_last)
  );

  mbox_match #(.NUM_PROTO(NUM_PROTO), .PROTO_TABLE(PROTO_TABLE)) u_match (
    .dword0  (hdr0),
    .hit     (hit),
    .hit_idx (hit_idx)
  );

  // next state
  always_comb begin
    busy_d  = busy_q;
    ready_d = ready_q;
    error_d = error_q;
    ien_d   = ien_q;
    start_d = go_ok;
    proto_d = go_ok ? hit_idx : proto_q;

    if (wr_ctl) ien_d = reg_wdata[CTL_IEN];

    if (abort) begin
      busy_d  = 1'b0;
      ready_d = 1'b0;
      error_d = 1'b0;
    end else begin
      if (go_ok)             busy_d  = 1'b1;
      if (done_ok | disc_ok) busy_d  = 1'b0;
      if (done_ok)           ready_d = 1'b1;
      if (drain_last)        ready_d = 1'b0;
      if (disc_ok)           error_d = 1'b1;
    end

    irq_d = INTR_SUP & ien_q & ((ready_d & ~ready_q) | (error_d & ~error_q));

    ists_d = ists_q;
    if (irq_d)                          ists_d = 1'b1;
    else if (wr_sts & reg_wdata[STS_ISTS]) ists_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q  <= 1'b0;
      ready_q <= 1'b0;
      error_q <= 1'b0;
      ien_q   <= 1'b0;
      ists_q  <= 1'b0;
      irq_q   <= 1'b0;
      start_q <= 1'b0;
      proto_q <= '0;
    end else begin
      busy_q  <= busy_d;
      ready_q <= ready_d;
      error_q <= error_d;
      ien_q   <= ien_d;
      ists_q  <= ists_d;
      irq_q   <= irq_d;
      start_q <= start_d;
      proto_q <= proto_d;
    end
  end

  // read path
  always_comb begin
    reg_rdata = '0;
    if (reg_rd) begin
      case (sel)
        SEL_CAP: reg_rdata = {20'h0, INTR_MSG, INTR_SUP};
        SEL_CTL: reg_rdata[CTL_IEN] = ien_q;
        SEL_STS: begin
          reg_rdata[STS_BUSY] = busy_q;
          reg_rdata[STS_ISTS] = ists_q;
          reg_rdata[STS_ERR]  = error_q;
          reg_rdata[STS_RDY]  = ready_q;
        end
        SEL_RMB: reg_rdata = ready_q ? rsp_cur : '0;
        default: reg_rdata = '0;
      endcase
    end
  end

  assign rsp_start = start_q;
  assign rsp_proto = proto_q;
  assign irq       = irq_q;

  // R5: the responder is only started together with busy
  a_r5_start_busy: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_start |-> busy_q);

  // R7: busy and ready are never set together
  a_r7_busy_ready_excl: assert property (@(posedge clk) disable iff (!rst_n)
    !(busy_q && ready_q));

  // R9: an abort leaves the block idle
  a_r9_abort_idle: assert property (@(posedge clk) disable iff (!rst_n)
    abort |=> !busy_q && !ready_q && !error_q);

  // R11: every interrupt pulse follows a rising ready or error flag
  a_r11_irq_cause: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> ((ready_q && !$past(ready_q)) || (error_q && !$past(error_q))));

  // R11: no interrupt pulse while interrupts were disabled
  a_r11_irq_enabled: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> $past(ien_q));

  // R11: interrupt pulses last a single cycle
  a_r11_irq_single: assert property (@(posedge clk) disable iff (!rst_n)
    irq |=> !irq);

endmodule

// File: tb/tb_mbox_regif.sv
module tb_mbox_regif;

  localparam int DEPTH = 16;
  localparam int IW = $clog2(DEPTH);
  localparam int PW = 1;
  localparam time TCK = 20ns;

  localparam logic [4:0] A_HDR = 5'h00, A_CAP = 5'h04, A_CTL = 5'h08,
                         A_STS = 5'h0C, A_WMB = 5'h10, A_RMB = 5'h14;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          reg_wr, reg_rd;
  logic [4:0]    reg_addr;
  logic [31:0]   reg_wdata, reg_rdata;
  logic          rsp_start;
  logic [PW-1:0] rsp_proto;
  logic [IW-1:0] rq_idx;
  logic [31:0]   rq_data;
  logic          rs_we;
  logic [31:0]   rs_data;
  logic          rsp_done, rsp_discard;
  logic          irq;

  always #(TCK/2) clk = ~clk;

  mbox_regif dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .rsp_start(rsp_start), .rsp_proto(rsp_proto), .rq_idx(rq_idx),
    .rq_data(rq_data), .rs_we(rs_we), .rs_data(rs_data),
    .rsp_done(rsp_done), .rsp_discard(rsp_discard), .irq(irq)
  );

  int n_chk = 0, n_err = 0;
  int n_irq = 0, n_start = 0;
  int last_proto = -1;
  logic [31:0] exp_q[$];
  string       tag_q[$];

  task automatic check(input bit ok, input string tag,
                       input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
    end
  endtask

  // monitor: pops expected read data a quarter period after drive
  initial begin
    forever begin
      @(negedge clk);
      #(TCK/4);
      if (irq) n_irq++;
      if (rsp_start) begin
        n_start++;
        last_proto = int'(rsp_proto);
      end
      if (reg_rd && exp_q.size() > 0) begin
        logic [31:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check(reg_rdata === e, t, reg_rdata, e);
      end
    end
  end

  // responder model
  initial begin
    rq_idx = '0; rs_we = 1'b0; rs_data = '0; rsp_done = 1'b0; rsp_discard = 1'b0;
    forever begin
      @(negedge clk);
      #(TCK/4);
      if (rsp_start && rst_n) begin
        int p;
        p = int'(rsp_proto);
        rq_idx = IW'(2);
        repeat (3) @(negedge clk);
        if (p == 0) begin
          rs_we = 1'b1; rs_data = 32'h0000_0001;
          @(negedge clk); rs_data = 32'h0000_0003;
          @(negedge clk); rs_data = rq_data ^ 32'hA5A5_A5A5;
          @(negedge clk); rs_we = 1'b0; rsp_done = 1'b1;
          @(negedge clk); rsp_done = 1'b0;
        end else begin
          rsp_discard = 1'b1;
          @(negedge clk); rsp_discard = 1'b0;
        end
      end
    end
  end

  // driver tasks: called at a negedge, return at the next one
  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, input logic [31:0] e, input string t);
    exp_q.push_back(e);
    tag_q.push_back(t);
    reg_rd = 1'b1; reg_addr = a;
    @(negedge clk);
    reg_rd = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic good_req(input logic [31:0] pay);
    wr(A_WMB, 32'h0000_0001);
    wr(A_WMB, 32'h0000_0003);
    wr(A_WMB, pay);
  endtask

  bit done_flag = 1'b0;

  initial begin
    #(TCK * 200000);
    if (!done_flag) begin
      n_chk++; n_err++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; reg_wr = 1'b0; reg_rd = 1'b0; reg_addr = '0; reg_wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    rd(A_STS, 32'h0, "R1 status after reset");
    rd(A_CTL, 32'h0, "R1 control after reset");
    check(irq == 1'b0, "R1 irq after reset", {31'h0, irq}, 32'h0);

    // R2 capabilities and empty offsets
    rd(A_CAP, 32'h0000_000B, "R2 capabilities");
    rd(A_HDR, 32'h0, "R2 header offset");
    rd(5'h18, 32'h0, "R2 offset 0x18");
    rd(5'h1C, 32'h0, "R2 offset 0x1C");

    // R3 interrupt enable stored
    wr(A_CTL, 32'h0000_0002);
    rd(A_CTL, 32'h0000_0002, "R3 enable readback");

    // R4 R5 R7 R8 R11 full exchange
    good_req(32'h1234_5678);
    wr(A_CTL, 32'h8000_0002);
    rd(A_STS, 32'h0000_0001, "R5 busy after start");
    idle(12);
    check(n_start == 1, "R5 start pulse count", n_start, 1);
    check(last_proto == 0, "R5 protocol index", last_proto, 0);
    rd(A_STS, 32'h8000_0002, "R7 ready with interrupt status");
    check(n_irq == 1, "R11 irq on ready", n_irq, 1);
    rd(A_CTL, 32'h0000_0002, "R3 start reads zero");
    rd(A_RMB, 32'h0000_0001, "R7 reply dword 0");
    wr(A_RMB, 32'h0);
    rd(A_RMB, 32'h0000_0003, "R8 reply dword 1");
    wr(A_RMB, 32'hFFFF_FFFF);
    rd(A_RMB, 32'hB791_F3DD, "R8 reply dword 2");
    wr(A_RMB, 32'h0);
    rd(A_STS, 32'h0000_0002, "R8 ready clear after drain");
    rd(A_RMB, 32'h0, "R7 read mailbox zero when not ready");
    wr(A_STS, 32'h0000_0002);
    rd(A_STS, 32'h0, "R11 interrupt status cleared");

    // R6 length mismatch then recovery
    wr(A_WMB, 32'h0000_0001);
    wr(A_WMB, 32'h0000_0004);
    wr(A_WMB, 32'h0000_AAAA);
    wr(A_CTL, 32'h8000_0002);
    rd(A_STS, 32'h0, "R6 length mismatch discarded");
    check(n_start == 1, "R6 no start on mismatch", n_start, 1);
    good_req(32'h0);
    wr(A_CTL, 32'h8000_0002);
    idle(12);
    rd(A_STS, 32'h8000_0002, "R6 recovery request ready");
    rd(A_RMB, 32'h0000_0001, "R6 fresh buffer after discard");

    // R9 abort
    wr(A_CTL, 32'h0000_0003);
    rd(A_STS, 32'h0000_0002, "R9 abort clears ready");
    rd(A_RMB, 32'h0, "R9 reply gone after abort");
    wr(A_STS, 32'h0000_0002);

    // R5 unknown protocol and reserved bits
    wr(A_WMB, 32'h0000_0002);
    wr(A_WMB, 32'h0000_0002);
    wr(A_CTL, 32'h8000_0002);
    rd(A_STS, 32'h0, "R5 unknown vendor rejected");
    wr(A_WMB, 32'h0100_0001);
    wr(A_WMB, 32'h0000_0002);
    wr(A_CTL, 32'h8000_0002);
    rd(A_STS, 32'h0, "R5 reserved bits rejected");
    check(n_start == 2, "R5 no start on mismatch", n_start, 2);

    // R10 responder discard
    wr(A_WMB, 32'h0001_0001);
    wr(A_WMB, 32'h0000_0002);
    wr(A_CTL, 32'h8000_0002);
    rd(A_STS, 32'h0000_0001, "R10 busy before discard");
    idle(12);
    check(last_proto == 1, "R5 second table entry", last_proto, 1);
    rd(A_STS, 32'h0000_0006, "R10 error after discard");
    check(n_irq == 3, "R11 irq on error", n_irq, 3);
    wr(A_CTL, 32'h0000_0003);
    rd(A_STS, 32'h0000_0002, "R9 abort clears error");
    wr(A_STS, 32'h0000_0002);

    // R4 overflow forces discard even with matching length
    wr(A_WMB, 32'h0000_0001);
    wr(A_WMB, 32'h0000_0010);
    for (int i = 0; i < DEPTH - 1; i++) wr(A_WMB, 32'(i));
    wr(A_CTL, 32'h8000_0002);
    rd(A_STS, 32'h0, "R4 overflow discarded");
    check(n_start == 3, "R4 no start on overflow", n_start, 3);
    good_req(32'h0);
    wr(A_CTL, 32'h8000_0002);
    idle(12);
    rd(A_STS, 32'h8000_0002, "R4 accepted after overflow");
    wr(A_CTL, 32'h0000_0003);
    wr(A_STS, 32'h0000_0002);

    // R11 interrupts disabled
    wr(A_CTL, 32'h0000_0000);
    good_req(32'h0);
    wr(A_CTL, 32'h8000_0000);
    idle(12);
    rd(A_STS, 32'h8000_0000, "R11 no interrupt status when disabled");
    check(n_irq == 4, "R11 no irq when disabled", n_irq, 4);
    wr(A_CTL, 32'h0000_0001);
    rd(A_STS, 32'h0, "R9 abort idle");

    // R9 abort wins over start
    good_req(32'h0);
    wr(A_CTL, 32'h8000_0001);
    rd(A_STS, 32'h0, "R9 abort with start");
    idle(12);
    check(n_start == 5, "R9 no start with abort", n_start, 5);
    rd(A_STS, 32'h0, "R9 still idle");

    idle(2);
    done_flag = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

endmodule